// File: doc/BRIEF.md
# DMA Completion Interrupt Router

This block gathers the completion interrupt levels of a bank of DMA channels and presents them two ways. The first is a global status word in the DMA register space, with one bit per channel. The second is a small two-level interrupt controller. The first eleven channels each own a peripheral interrupt line. The remaining channels are merged onto one shared line.

The peripheral lines occupy a contiguous field of the controller's first pending bank. A first-level ("basic") pending word carries a summary bit that is set whenever anything in that bank is pending. An enable word selects which bank lines may raise the single CPU interrupt. Pending state is level-sensitive: it follows the channel flags and falls as soon as a channel's flag is cleared at its source.

Software reaches the registers through a request/response port. A request is taken on a clock edge where `reg_valid` and `reg_ready` are both high. Exactly one response follows for every request. It stays on `rsp_valid`/`rsp_data` until the edge where `rsp_ready` is high. `reg_ready` is low only while an unconsumed response is waiting and `rsp_ready` is low, so a stalled consumer back-pressures new requests without losing the held response.

Top module: `dma_irq_router`

## Requirements
- R1: After reset, `cpu_irq` and `rsp_valid` are 0, and every register described here reads 0 while no channel flag is high.
- R2: A read with `reg_space`=0 at address 0xFE0 returns bit n equal to channel n's flag as registered at the previous clock edge; all bits above the channel count read 0.
- R3: Writes to the global status word (space 0, address 0xFE0) are ignored: its following read still shows only the channel flags.
- R4: Channel k, for k from 0 to 10, sets bit 16+k of the first pending bank (space 1, address 0x04) and no other bit.
- R5: Channels 11 to 14 are ORed onto bit 27 of the first pending bank; any one of them, or several, sets that single bit.
- R6: The basic pending word (space 1, address 0x00) has bit 8 set exactly when any bit of the first pending bank is set; all its other bits read 0.
- R7: Pending bits are levels: once every channel on a line is low for one clock, the line's pending bit and the bit-8 summary read 0 again.
- R8: The enable word (space 1, address 0x10) is write-1-to-set over bits 16 to 27 (mask 0x0FFF0000): written 1s in that range set the bit, written 0s leave it alone, and bits outside the range read 0. Only reset clears it.
- R9: `cpu_irq` is high exactly when some first-bank bit is both pending and enabled, one clock after the pending bit or enable bit changes, that is, two clocks after a channel flag edge.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `reg_ready` is low, and `rsp_data` and `rsp_valid` hold unchanged.
- R11: Reads of any other address in either space return 0; writes there have no effect, including writes to the read-only pending words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_irq | input | 15 | Per-channel completion interrupt levels |
| reg_valid | input | 1 | Register request present |
| reg_ready | output | 1 | Register request can be taken this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_space | input | 1 | 0 = DMA block space, 1 = interrupt controller space |
| reg_addr | input | 12 | Byte offset within the selected space |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 32 | Read data (0 for write responses) |
| cpu_irq | output | 1 | Combined CPU interrupt |

## Verification
The hardest situation to reach from the ports is the stalled response: a read result has to stay fixed while the channel flags it captured keep changing, and a second request has to be held off at the same moment. The bench withholds `rsp_ready` after a status read and moves the channel flags. It then keeps a second request asserted through the stall and releases the consumer, so that the held response and the waiting request hand over on the same edge. The shared line is driven with single, mixed and all-high patterns of the upper channels, and random mixes of channel flags and enable writes run against bench-side models of the pending, summary and interrupt words.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] GSTAT_OFS  = 12'hFE0;
  localparam logic [ADDR_W-1:0] BASIC_OFS  = 12'h000;
  localparam logic [ADDR_W-1:0] BANK1_OFS  = 12'h004;
  localparam logic [ADDR_W-1:0] ENABLE_OFS = 12'h010;

  localparam int unsigned SUMMARY_BIT = 8;

  typedef enum logic {
    SPACE_DMA = 1'b0,
    SPACE_IC  = 1'b1
  } space_e;

  typedef struct packed {
    logic [DATA_W-1:0] gstat;
    logic [DATA_W-1:0] basic;
    logic [DATA_W-1:0] bank1;
    logic [DATA_W-1:0] enable;
  } view_t;
endpackage

// File: rtl/dirq_line_map.sv
module dirq_line_map #(
  parameter int unsigned NUM_CH   = 15,
  parameter int unsigned NUM_SOLO = 11,
  localparam int unsigned NUM_LINES = NUM_SOLO + 1
) (
  input  logic [NUM_CH-1:0]    src,
  output logic [NUM_LINES-1:0] lines
);
  for (genvar k = 0; k < NUM_SOLO; k++) begin : g_solo
    assign lines[k] = src[k];
  end
  assign lines[NUM_LINES-1] = |src[NUM_CH-1:NUM_SOLO];
endmodule

// File: rtl/dirq_ic.sv
module dirq_ic
  import dirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 12,
  parameter int unsigned LINE_BASE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic                 en_set,
  input  logic [DATA_W-1:0]    en_wdata,
  output logic [DATA_W-1:0]    bank1,
  output logic [DATA_W-1:0]    basic,
  output logic [DATA_W-1:0]    enable,
  output logic                 irq
);
  logic [NUM_LINES-1:0] en_q;
  logic                 irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_set) en_q <= en_q | en_wdata[LINE_BASE +: NUM_LINES];
      irq_q <= |(lines & en_q);
    end
  end

  always_comb begin
    bank1 = '0;
    bank1[LINE_BASE +: NUM_LINES] = lines;
    enable = '0;
    enable[LINE_BASE +: NUM_LINES] = en_q;
    basic = '0;
    basic[SUMMARY_BIT] = |bank1;
  end

  assign irq = irq_q;
endmodule

// File: rtl/dirq_regport.sv
module dirq_regport
  import dirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  view_t             view,
  output logic              en_set,
  output logic [DATA_W-1:0] en_wdata
);
  logic              fire;
  logic              vld_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = !vld_q || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_comb begin
    rd_mux = '0;
    if (space_e'(req_space) == SPACE_DMA) begin
      if (req_addr == GSTAT_OFS) rd_mux = view.gstat;
    end else begin
      unique case (req_addr)
        BASIC_OFS:  rd_mux = view.basic;
        BANK1_OFS:  rd_mux = view.bank1;
        ENABLE_OFS: rd_mux = view.enable;
        default:    rd_mux = '0;
      endcase
    end
  end

  assign en_set   = fire && req_write && (space_e'(req_space) == SPACE_IC)
                    && (req_addr == ENABLE_OFS);
  assign en_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (fire) begin
      vld_q  <= 1'b1;
      data_q <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;
endmodule

// File: rtl/dma_irq_router.sv
module dma_irq_router
  import dirq_pkg::*;
#(
  parameter int unsigned NUM_CH    = 15,
  parameter int unsigned NUM_SOLO  = 11,
  parameter int unsigned LINE_BASE = 16,
  localparam int unsigned NUM_LINES = NUM_SOLO + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_irq,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic              reg_space,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              cpu_irq
);
  logic [NUM_CH-1:0]    stat_q;
  logic [NUM_LINES-1:0] lines;
  logic                 en_set;
  logic [DATA_W-1:0]    en_wdata;
  view_t                view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= chan_irq;
  end

  assign view.gstat = DATA_W'(stat_q);

  dirq_line_map #(.NUM_CH(NUM_CH), .NUM_SOLO(NUM_SOLO)) u_map (
    .src   (stat_q),
    .lines (lines)
  );

  dirq_ic #(.NUM_LINES(NUM_LINES), .LINE_BASE(LINE_BASE)) u_ic (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (lines),
    .en_set   (en_set),
    .en_wdata (en_wdata),
    .bank1    (view.bank1),
    .basic    (view.basic),
    .enable   (view.enable),
    .irq      (cpu_irq)
  );

  dirq_regport u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (reg_valid),
    .req_ready (reg_ready),
    .req_write (reg_write),
    .req_space (reg_space),
    .req_addr  (reg_addr),
    .req_wdata (reg_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .view      (view),
    .en_set    (en_set),
    .en_wdata  (en_wdata)
  );
endmodule

// File: rtl/dirq_checker.sv
module dirq_checker #(
  parameter int unsigned NUM_CH    = 15,
  parameter int unsigned NUM_LINES = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CH-1:0]    chan_irq,
  input logic [NUM_CH-1:0]    stat_q,
  input logic [NUM_LINES-1:0] lines,
  input logic [31:0]          enable,
  input logic                 cpu_irq,
  input logic                 reg_ready,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [31:0]          rsp_data
);
  localparam int unsigned SOLO = NUM_LINES - 1;
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (stat_q == $past(chan_irq)));

  a_r5_shared_needs_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lines[NUM_LINES-1]) |-> $past(|chan_irq[NUM_CH-1:SOLO]));

  a_r8_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(enable) & ~enable) == 32'h0));

  a_r9_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cpu_irq) |-> $past(|stat_q));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r10_no_take_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !reg_ready);
endmodule

bind dma_irq_router dirq_checker #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_irq  (chan_irq),
  .stat_q    (stat_q),
  .lines     (lines),
  .enable    (view.enable),
  .cpu_irq   (cpu_irq),
  .reg_ready (reg_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/sim_dma_irq_router.sv
`timescale 1ns/1ps
module sim_dma_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] chan_irq = '0;
  logic        reg_valid = 1'b0;
  logic        reg_ready;
  logic        reg_write = 1'b0;
  logic        reg_space = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] en_model = '0;

  always #10 clk = ~clk;

  dma_irq_router u0 (.*);

  function automatic logic [31:0] f_bank1(input logic [14:0] ch);
    logic [31:0] r = '0;
    for (int k = 0; k < 11; k++) r[16+k] = ch[k];
    r[27] = |ch[14:11];
    return r;
  endfunction

  function automatic logic [31:0] f_basic(input logic [14:0] ch);
    logic [31:0] r = '0;
    r[8] = |f_bank1(ch);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic sp, input logic [11:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    while (!reg_ready) @(negedge clk);
    reg_valid = 1'b1; reg_write = wr; reg_space = sp; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    reg_valid = 1'b0;
    rd = rsp_data;
  endtask

  task automatic rd(input logic sp, input logic [11:0] a, output logic [31:0] d);
    access(1'b0, sp, a, 32'h0, d);
  endtask

  task automatic wr(input logic sp, input logic [11:0] a, input logic [31:0] wd);
    logic [31:0] unused;
    access(1'b1, sp, a, wd, unused);
    if (sp == 1'b1 && a == 12'h010) en_model |= wd & 32'h0FFF_0000;
  endtask

  task automatic set_ch(input logic [14:0] v);
    @(negedge clk);
    chan_irq = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag, input logic [14:0] ch);
    logic [31:0] d;
    rd(1'b0, 12'hFE0, d); check({tag, " R2 status"}, d, {17'h0, ch});
    rd(1'b1, 12'h004, d); check({tag, " R4/R5 bank1"}, d, f_bank1(ch));
    rd(1'b1, 12'h000, d); check({tag, " R6 basic"}, d, f_basic(ch));
    rd(1'b1, 12'h010, d); check({tag, " R8 enable"}, d, en_model);
    check({tag, " R9 cpu_irq"}, {31'h0, cpu_irq}, {31'h0, |(f_bank1(ch) & en_model)});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    en_model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 cpu_irq", {31'h0, cpu_irq}, 32'h0);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check_all("R1", 15'h0);

    // R4 each dedicated channel alone, lines enabled
    wr(1'b1, 12'h010, 32'h0FFF_0000);
    for (int k = 0; k < 11; k++) begin
      set_ch(15'(1) << k);
      rd(1'b1, 12'h004, d); check("R4 solo channel", d, 32'h1 << (16 + k));
    end
    // R5 shared line patterns
    set_ch(15'h0800); check_all("R5 ch11", 15'h0800);
    set_ch(15'h4000); check_all("R5 ch14", 15'h4000);
    set_ch(15'h7800); check_all("R5 all upper", 15'h7800);
    set_ch(15'h2401); check_all("R5 mixed", 15'h2401);
    // R7 level drop
    set_ch(15'h0);
    rd(1'b1, 12'h004, d); check("R7 bank1 drops", d, 32'h0);
    rd(1'b1, 12'h000, d); check("R7 summary drops", d, 32'h0);
    check("R7 cpu_irq drops", {31'h0, cpu_irq}, 32'h0);

    // R3 writes to status ignored
    chan_irq = 15'h0005;
    wr(1'b0, 12'hFE0, 32'hFFFF_FFFF);
    rd(1'b0, 12'hFE0, d); check("R3 status write ignored", d, 32'h0000_0005);
    // R11 unmapped and read-only words
    wr(1'b1, 12'h004, 32'hFFFF_FFFF);
    wr(1'b1, 12'h000, 32'hFFFF_FFFF);
    rd(1'b1, 12'h004, d); check("R11 bank1 write ignored", d, f_bank1(15'h0005));
    rd(1'b1, 12'h008, d); check("R11 unmapped ic", d, 32'h0);
    rd(1'b0, 12'h100, d); check("R11 unmapped dma", d, 32'h0);
    set_ch(15'h0);

    // R8 write-1-to-set and R9 timing, after fresh reset
    do_reset();
    wr(1'b1, 12'h010, 32'hF000_0001 | 32'h0000_8000);
    rd(1'b1, 12'h010, d); check("R8 outside mask", d, 32'h0);
    wr(1'b1, 12'h010, 32'h0001_0000);
    wr(1'b1, 12'h010, 32'h0000_0000);
    rd(1'b1, 12'h010, d); check("R8 zero keeps", d, 32'h0001_0000);
    set_ch(15'h0002);
    check("R9 disabled line no irq", {31'h0, cpu_irq}, 32'h0);
    set_ch(15'h0);
    @(negedge clk);
    chan_irq = 15'h0001;
    @(negedge clk);
    check("R9 irq not after one edge", {31'h0, cpu_irq}, 32'h0);
    @(negedge clk);
    check("R9 irq after two edges", {31'h0, cpu_irq}, 32'h1);
    chan_irq = 15'h0;
    @(negedge clk); @(negedge clk);
    check("R9 irq falls", {31'h0, cpu_irq}, 32'h0);

    // R10 stalled response with a waiting request
    chan_irq = 15'h1234;
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(1'b0, 12'hFE0, held);
    check("R10 captured", held, 32'h0000_1234);
    chan_irq = 15'h0F0F;
    reg_valid = 1'b1; reg_write = 1'b0; reg_space = 1'b1; reg_addr = 12'h004;
    repeat (3) @(negedge clk);
    check("R10 data held", rsp_data, 32'h0000_1234);
    check("R10 ready low", {31'h0, reg_ready}, 32'h0);
    rsp_ready = 1'b1;
    @(negedge clk);
    reg_valid = 1'b0;
    check("R10 handover", rsp_data, f_bank1(15'h0F0F));
    check("R10 valid", {31'h0, rsp_valid}, 32'h1);
    set_ch(15'h0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [14:0] ch;
      ch = 15'($urandom);
      if ($urandom_range(0, 3) == 0) wr(1'b1, 12'h010, $urandom & $urandom);
      if (i == 30) do_reset();
      set_ch(ch);
      check_all("RND", ch);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule